// File: doc/BRIEF.md
# Shared External Bus Arbiter

This block decides which agent owns a shared external bus. It serves a group of peer processors (six by default) and one host. Each processor has its own request line and the host has one more. The arbiter returns a one-hot grant vector, with one bit for each processor and a top bit for the host, together with a numeric owner code.

A mode input picks the priority scheme. In fixed order the lowest-numbered processor always wins. In rotating order the search for a winner starts just after the processor that held the bus most recently. The host wins over every processor whenever an arbitration takes place, and while a processor holds the bus a host request forces a handover. A lock input lets the current owner keep the bus through an indivisible read-modify-write sequence. While lock is high, neither its own released request nor a host request can take the bus away.

Every handover leaves the bus ungranted for exactly one cycle. Arbitration happens only while no agent owns the bus, and the chosen winner is registered at the next clock edge.

Top module: `shared_bus_arbiter`

## Requirements
- R1: After reset, grant is all zero and owner_id holds the idle code (all ones, 7 with the default parameters).
- R2: At most one grant bit is high. When bit k is high, owner_id equals k. Processor n uses bit n and the host uses bit NPROC (code 6 by default).
- R3: With rotate_mode = 0, an arbitration among processor requests grants the lowest-numbered requesting processor.
- R4: With rotate_mode = 1, the search starts at the processor numbered one above the most recent processor owner, wrapping from NPROC-1 to 0. After reset the most recent owner counts as NPROC-1.
- R5: If host_req is high during an arbitration cycle, the host is granted, whatever processor requests are present.
- R6: An owner keeps the grant unchanged for as long as its own request stays high, unless a host preemption (R8) applies.
- R7: When the owner releases the bus, grant is all zero for exactly one cycle. If requests are pending in that cycle, the winner is granted on the next edge. From the idle state, a request sampled at an edge is granted at that same edge.
- R8: While a processor owns the bus and lock is low, host_req causes one all-zero grant cycle, followed by the host grant.
- R9: While lock is high, the current owner keeps the grant, even if its own request has dropped and host_req is high.
- R10: With no request present, no grant is given and owner_id stays at the idle code. Lock has no effect while the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_req | input | NPROC | Bus request, one bit for each processor |
| host_req | input | 1 | Host bus request |
| rotate_mode | input | 1 | 0 = fixed priority, 1 = rotating priority |
| lock | input | 1 | Owner holds the bus for an atomic sequence |
| grant | output | NPROC+1 | One-hot grant; bit NPROC is the host |
| owner_id | output | $clog2(NPROC+2) | Current owner code, all ones when idle |

## Verification
Three functions can land in the same cycle: lock, an owner's release, and a host request. The lock test takes these in sequence. A processor owns the bus and lock goes high. Its request then drops while host_req rises, so the release and the preemption are both pending behind the lock at once. The grant must not change for as long as lock stays high. When lock falls, one empty cycle and then a host grant must follow. A second same-cycle collision puts a host request next to a processor request in the arbitration cycle, and the host must win.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    PRIO_FIXED  = 1'b0,
    PRIO_ROTATE = 1'b1
  } prio_mode_e;
endpackage

// File: rtl/arb_pick.sv
// Priority picker over processor requests; fixed or rotating search start.
module arb_pick #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  input  logic          rotate,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      int c;
      c = rotate ? ((int'(start) + k) % N) : k;
      if (!found && req[c]) begin
        found = 1'b1;
        idx   = IW'(c);
      end
    end
  end
endmodule

// File: rtl/arb_owner_ctl.sv
// Ownership state: owner valid flag, owner code, most recent processor owner.
module arb_owner_ctl
  import arb_pkg::*;
#(
  parameter int NPROC = 6,
  parameter int IW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPROC-1:0] proc_req,
  input  logic             host_req,
  input  logic             lock,
  input  logic             pick_found,
  input  logic [IW-1:0]    pick_idx,
  output logic             own_v,
  output logic [IW-1:0]    own_id,
  output logic [IW-1:0]    last_proc
);
  localparam logic [IW-1:0] HOST_ID = IW'(NPROC);
  localparam logic [IW-1:0] LAST_RST = IW'(NPROC - 1);

  logic          own_v_n;
  logic [IW-1:0] own_id_n;
  logic [IW-1:0] last_n;
  logic          own_en;
  logic          last_en;
  logic          owner_req;
  logic          owner_is_host;
  logic          release_bus;

  assign owner_is_host = (own_id == HOST_ID);
  assign owner_req     = owner_is_host ? host_req : proc_req[own_id];
  assign release_bus   = !lock && (!owner_req || (!owner_is_host && host_req));

  always_comb begin
    own_v_n  = own_v;
    own_id_n = own_id;
    last_n   = last_proc;
    own_en   = 1'b0;
    last_en  = 1'b0;
    if (own_v) begin
      if (release_bus) begin
        own_en  = 1'b1;
        own_v_n = 1'b0;
      end
    end else if (host_req) begin
      own_en   = 1'b1;
      own_v_n  = 1'b1;
      own_id_n = HOST_ID;
    end else if (pick_found) begin
      own_en   = 1'b1;
      last_en  = 1'b1;
      own_v_n  = 1'b1;
      own_id_n = pick_idx;
      last_n   = pick_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_v  <= 1'b0;
      own_id <= '0;
    end else if (own_en) begin
      own_v  <= own_v_n;
      own_id <= own_id_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_proc <= LAST_RST;
    end else if (last_en) begin
      last_proc <= last_n;
    end
  end
endmodule

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter
  import arb_pkg::*;
#(
  parameter int NPROC = 6,
  localparam int IW   = $clog2(NPROC + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPROC-1:0] proc_req,
  input  logic             host_req,
  input  logic             rotate_mode,
  input  logic             lock,
  output logic [NPROC:0]   grant,
  output logic [IW-1:0]    owner_id
);
  localparam logic [IW-1:0] IDLE_ID = {IW{1'b1}};

  prio_mode_e    mode;
  logic          own_v;
  logic [IW-1:0] own_id;
  logic [IW-1:0] last_proc;
  logic [IW-1:0] search_start;
  logic          pick_found;
  logic [IW-1:0] pick_idx;

  assign mode         = prio_mode_e'(rotate_mode);
  assign search_start = (last_proc == IW'(NPROC - 1)) ? '0 : last_proc + 1'b1;

  arb_pick #(.N(NPROC), .IW(IW)) u_pick (
    .req    (proc_req),
    .start  (search_start),
    .rotate (mode == PRIO_ROTATE),
    .found  (pick_found),
    .idx    (pick_idx)
  );

  arb_owner_ctl #(.NPROC(NPROC), .IW(IW)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .proc_req   (proc_req),
    .host_req   (host_req),
    .lock       (lock),
    .pick_found (pick_found),
    .pick_idx   (pick_idx),
    .own_v      (own_v),
    .own_id     (own_id),
    .last_proc  (last_proc)
  );

  for (genvar g = 0; g <= NPROC; g++) begin : g_grant
    assign grant[g] = own_v && (own_id == IW'(g));
  end

  assign owner_id = own_v ? own_id : IDLE_ID;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NPROC = 6,
  parameter int IW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPROC-1:0] proc_req,
  input logic             host_req,
  input logic             lock,
  input logic [NPROC:0]   grant,
  input logic [IW-1:0]    owner_id
);
  logic [NPROC:0] all_req;
  assign all_req = {host_req, proc_req};

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2
  AST_ID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> grant[owner_id]); // R2
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |-> (owner_id == {IW{1'b1}})); // R10
  AST_GAP_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> (grant == '0 || grant == $past(grant))); // R7
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && lock) |=> (grant == $past(grant))); // R9
  AST_OWNER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & all_req) != '0 && !(host_req && !grant[NPROC])) |=> $stable(grant)); // R6
  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && host_req) |=> grant[NPROC]); // R5
  AST_STAY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && all_req == '0) |=> (grant == '0)); // R10
endmodule

bind shared_bus_arbiter arb_checker #(.NPROC(NPROC), .IW(IW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .proc_req (proc_req),
  .host_req (host_req),
  .lock     (lock),
  .grant    (grant),
  .owner_id (owner_id)
);

// File: tb/sim_shared_bus_arbiter.sv
`timescale 1ns/1ps
module sim_shared_bus_arbiter;
  localparam int NPROC = 6;
  localparam int IW    = 3;
  localparam logic [IW-1:0] IDLE = 3'd7;
  localparam logic [IW-1:0] HOST = 3'd6;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NPROC-1:0] proc_req;
  logic             host_req;
  logic             rotate_mode;
  logic             lock;
  logic [NPROC:0]   grant;
  logic [IW-1:0]    owner_id;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  shared_bus_arbiter #(.NPROC(NPROC)) u0 (
    .clk(clk), .rst_n(rst_n), .proc_req(proc_req), .host_req(host_req),
    .rotate_mode(rotate_mode), .lock(lock), .grant(grant), .owner_id(owner_id)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_owner(input string req, input logic [IW-1:0] id);
    logic [NPROC:0] eg;
    eg = (id == IDLE) ? '0 : (7'd1 << id);
    checks++;
    if (grant !== eg || owner_id !== id) begin
      errors++;
      $display("FAIL %s grant=%b id=%0d expected grant=%b id=%0d", req, grant, owner_id, eg, id);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; proc_req = '0; host_req = 1'b0; lock = 1'b0; rotate_mode = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic go_idle();
    proc_req = '0; host_req = 1'b0; lock = 1'b0;
    step(); step();
  endtask

  task automatic t_reset();
    do_reset();
    expect_owner("R1 reset", IDLE);
  endtask

  task automatic t_fixed();
    go_idle(); rotate_mode = 1'b0;
    proc_req = 6'b101100; step();
    expect_owner("R3 lowest wins", 3'd2);
    step();
    expect_owner("R6 owner keeps", 3'd2);
    proc_req = 6'b101000; step();
    expect_owner("R7 gap after release", IDLE);
    step();
    expect_owner("R7 R3 next winner", 3'd3);
  endtask

  task automatic t_rotate();
    do_reset(); rotate_mode = 1'b1;
    proc_req = 6'b010001; step();
    expect_owner("R4 start at 0 after reset", 3'd0);
    proc_req = 6'b010010; step(); step();
    expect_owner("R4 after 0 picks 1", 3'd1);
    proc_req = 6'b010001; step(); step();
    expect_owner("R4 after 1 picks 4 not 0", 3'd4);
    proc_req = 6'b100001; step(); step();
    expect_owner("R4 after 4 picks 5", 3'd5);
    proc_req = 6'b000011; step(); step();
    expect_owner("R4 wrap picks 0", 3'd0);
  endtask

  task automatic t_host();
    go_idle(); rotate_mode = 1'b0;
    proc_req = 6'b000001; host_req = 1'b1; step();
    expect_owner("R5 host beats processor", HOST);
    host_req = 1'b0; step();
    expect_owner("R7 gap after host", IDLE);
    step();
    expect_owner("R7 processor after host", 3'd0);
  endtask

  task automatic t_preempt();
    go_idle(); rotate_mode = 1'b0;
    proc_req = 6'b000100; step();
    expect_owner("R3 owner 2", 3'd2);
    host_req = 1'b1; step();
    expect_owner("R8 preempt gap", IDLE);
    step();
    expect_owner("R8 host granted", HOST);
  endtask

  task automatic t_lock();
    go_idle(); rotate_mode = 1'b0;
    proc_req = 6'b000010; step();
    expect_owner("R3 owner 1", 3'd1);
    lock = 1'b1; proc_req = 6'b000000; host_req = 1'b1; step();
    expect_owner("R9 lock holds", 3'd1);
    step();
    expect_owner("R9 lock still holds", 3'd1);
    lock = 1'b0; step();
    expect_owner("R9 R8 gap after unlock", IDLE);
    step();
    expect_owner("R9 host after unlock", HOST);
  endtask

  task automatic t_idle();
    go_idle();
    expect_owner("R10 idle", IDLE);
    lock = 1'b1; step();
    expect_owner("R10 lock alone ignored", IDLE);
    lock = 1'b0; step();
    expect_owner("R10 stays idle", IDLE);
  endtask

  initial begin
    rst_n = 1'b0; proc_req = '0; host_req = 1'b0; lock = 1'b0; rotate_mode = 1'b0;
    t_reset();
    t_fixed();
    t_rotate();
    t_host();
    t_preempt();
    t_lock();
    t_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule